// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes received frames from a byte stream and stores them in a circular receive buffer through a simple byte-write memory port. Every stored frame is preceded by a 32-bit little-endian header. The header holds the frame's receive status and its length, CRC bytes included. Payload bytes are written first, starting four bytes past the frame's start offset. The header is written in the four cycles after the last byte. Only then does the hardware write offset move to the next 4-byte-aligned slot.

Software reads frames out of the ring and reports its progress through a read-pointer register. That register holds the consumed offset less 16. The block reports an empty ring and raises receive-OK, receive-error, ring-overflow and input-overrun events in a write-one-to-clear status word. It also keeps a missed-frame counter that a write clears.

An accept mask selects which address classes are stored, and whether runt or errored frames are stored. The ring length is 8 KiB, 16 KiB or 32 KiB. A wrap-mode bit lets a frame run into 16 bytes of slack past the ring end instead of folding back to offset 0.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset `buf_empty` is 1, `rdptr` reads 0xFFF0, `int_stat` is 0, `missed` is 0 and no memory write is issued.
- R2: An accepted frame's header sits at the frame's start offset as four bytes, lowest first. Bits 31:16 hold the byte count including CRC. Bit 0 is set when `in_errs` is zero. Bits 5:1 copy `in_errs`, where `in_errs` bit 0 is alignment, bit 1 CRC, bit 2 too long, bit 3 runt and bit 4 bad symbol. Bit 13 marks broadcast, bit 14 own address and bit 15 multicast. `in_cls` encodes 0 other unicast, 1 own address, 2 multicast and 3 broadcast. All other header bits are 0.
- R3: With `cfg_wrap` at 0, payload byte i of a frame at offset S is written at (S+4+i) modulo the ring length.
- R4: After a frame of length N is committed at offset S, the write offset becomes ((S+N+4+3) rounded down to a multiple of 4) modulo the ring length.
- R5: The ring length is 8192 shifted left by `cfg_ring_idx`. An index of 3 behaves as 2.
- R6: `buf_empty` is 1 exactly when the write offset equals (`rdptr`+16) modulo the ring length. A write through `rdptr_we` is read back on `rdptr`.
- R7: `cfg_accept` decides which frames are stored. Bit 0 accepts any unicast. Bit 1 accepts own-address frames. Bit 2 accepts multicast and bit 3 accepts broadcast. A frame with the runt flag also needs bit 4. A frame with any other error flag also needs bit 5. A rejected frame leaves the offset, `int_stat` and `missed` unchanged.
- R8: A frame is stored only if its aligned slot size (N+4 rounded up to 4) is strictly less than the free space, which is the ring length minus the unconsumed bytes. An accepted frame that does not fit is dropped: the offset stays put, `missed` increments, `int_stat` bit 4 sets, and unconsumed data is not overwritten.
- R9: With `cfg_wrap` at 1, a payload position p = S+4+i goes to address p when p is below the ring length plus 16, and to p minus the ring length otherwise.
- R10: On commit, `int_stat` bit 0 sets for a frame without errors and bit 1 for an errored frame. A write on `int_clr_we` clears only the bits set in `int_clr_data`. A set in the same cycle wins over the clear.
- R11: A byte that arrives during the four header-write cycles sets `int_stat` bit 6. The frame it belongs to is discarded and counted in `missed` when its last byte arrives.
- R12: `missed` is 24 bits wide and adds one per dropped or lost frame. `miss_clr` zeroes it and takes precedence over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ring_idx | input | 2 | Ring size index |
| cfg_accept | input | 6 | Accept mask |
| cfg_wrap | input | 1 | Spill into slack instead of folding to 0 |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Last byte of the frame |
| in_cls | input | 2 | Destination class, valid with `in_last` |
| in_errs | input | 5 | Error flags, valid with `in_last` |
| rdptr_we | input | 1 | Read-pointer write strobe |
| rdptr_wdata | input | 16 | Read-pointer write value (consumed offset minus 16) |
| rdptr | output | 16 | Read-pointer register |
| int_clr_we | input | 1 | Interrupt-status clear strobe |
| int_clr_data | input | 16 | Bits to clear |
| int_stat | output | 16 | Interrupt status (bits 0, 1, 4, 6) |
| miss_clr | input | 1 | Clear missed-frame counter |
| missed | output | 24 | Missed-frame counter |
| buf_empty | output | 1 | No unconsumed frame in the ring |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |

## Verification
A wrong write offset shows up in two places. The next frame's header lands at an address the bench did not predict. Moving `rdptr` to the predicted slot also leaves `buf_empty` low. Both are visible within six cycles of that frame's last byte. A wrong free-space figure shows as a drop that should not happen, or a missing one, together with the matching `missed` and status-bit change. Payload placement faults in either wrap mode show as byte mismatches on the memory port during that same frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic {ST_DATA = 1'b0, ST_HDR = 1'b1} rxr_state_e;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_OWN   = 2'd1,
    CLS_MULTI = 2'd2,
    CLS_BCAST = 2'd3
  } rxr_cls_e;

  // ring length in bytes for a size index, clamped to the largest allowed index
  function automatic logic [31:0] ring_bytes(input logic [1:0] idx, input int base, input int max_idx);
    int eff;
    eff = (int'(idx) > max_idx) ? max_idx : int'(idx);
    return 32'(base) << eff;
  endfunction

  // bytes a frame of len bytes occupies: header plus data, rounded up to 4
  function automatic logic [31:0] slot_bytes(input logic [31:0] len);
    return (len + 32'd7) & ~32'd3;
  endfunction

  // physical byte address for a linear position past the frame start
  function automatic logic [31:0] place(input logic [31:0] pos, input logic [31:0] rlen, input logic wrap);
    if (!wrap) return pos & (rlen - 32'd1);
    return (pos < rlen + 32'd16) ? pos : pos - rlen;
  endfunction

endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int PTR_W = 16,
  localparam int LW = PTR_W + 1
) (
  input  logic [LW-1:0]    ring_len,
  input  logic [PTR_W-1:0] wr_off,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [LW-1:0]    free_bytes,
  output logic             empty
);
  logic [LW-1:0] cons_w, used_w;

  assign cons_w     = ({1'b0, rd_ptr} + LW'(16)) & (ring_len - LW'(1));
  assign used_w     = ({1'b0, wr_off} - cons_w) & (ring_len - LW'(1));
  assign free_bytes = ring_len - used_w;
  assign empty      = (used_w == '0);
endmodule

// File: rtl/rxr_status.sv
module rxr_status
  import rxr_pkg::*;
(
  input  logic [1:0]  cls,
  input  logic [4:0]  errs,
  input  logic [5:0]  accept,
  input  logic [15:0] len,
  output logic        take,
  output logic        is_err,
  output logic [31:0] hdr
);
  logic addr_ok, runt_ok, other_ok;

  always_comb begin
    case (rxr_cls_e'(cls))
      CLS_OTHER: addr_ok = accept[0];
      CLS_OWN:   addr_ok = accept[0] | accept[1];
      CLS_MULTI: addr_ok = accept[2];
      default:   addr_ok = accept[3];
    endcase
  end

  assign runt_ok  = !errs[3] || accept[4];
  assign other_ok = !(|{errs[4], errs[2:0]}) || accept[5];
  assign take     = addr_ok && runt_ok && other_ok;
  assign is_err   = |errs;
  assign hdr      = {len,
                     cls == CLS_MULTI, cls == CLS_OWN, cls == CLS_BCAST,
                     7'b0, errs, !is_err};
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq #(
  parameter int MISS_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_ok,
  input  logic              set_err,
  input  logic              set_ovf,
  input  logic              set_fifo,
  input  logic              clr_we,
  input  logic [15:0]       clr_data,
  input  logic              miss_inc,
  input  logic              miss_clr,
  output logic [15:0]       int_stat,
  output logic [MISS_W-1:0] missed
);
  localparam logic [15:0] LIVE = 16'h0053;
  logic [15:0] set_v, keep_m;

  assign set_v  = {9'b0, set_fifo, 1'b0, set_ovf, 2'b0, set_err, set_ok};
  assign keep_m = clr_we ? ~clr_data : 16'hFFFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_stat <= '0;
      missed   <= '0;
    end else begin
      int_stat <= ((int_stat & keep_m) | set_v) & LIVE;
      if (miss_clr)      missed <= '0;
      else if (miss_inc) missed <= missed + MISS_W'(1);
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int BASE_LEN = 8192,
  parameter int MAX_IDX  = 2,
  parameter int PTR_W    = 16,
  parameter int MISS_W   = 24,
  localparam int ADDR_W  = $clog2((BASE_LEN << MAX_IDX) + 16)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_ring_idx,
  input  logic [5:0]        cfg_accept,
  input  logic              cfg_wrap,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [1:0]        in_cls,
  input  logic [4:0]        in_errs,
  input  logic              rdptr_we,
  input  logic [PTR_W-1:0]  rdptr_wdata,
  output logic [PTR_W-1:0]  rdptr,
  input  logic              int_clr_we,
  input  logic [15:0]       int_clr_data,
  output logic [15:0]       int_stat,
  input  logic              miss_clr,
  output logic [MISS_W-1:0] missed,
  output logic              buf_empty,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int LW = PTR_W + 1;
  localparam logic [PTR_W-1:0] RD_RESET = {{(PTR_W-4){1'b1}}, 4'b0};

  rxr_state_e       st;
  logic [PTR_W-1:0] wr_off, cnt, rd_ptr, nxt_q;
  logic             lost, err_q;
  logic [1:0]       hk;
  logic [31:0]      hdr_q, hdr_w;
  logic [31:0]      ring_len, len_now, need;
  logic [LW-1:0]    free_bytes;
  logic             take, frame_err, fits, room;
  // named events, used by the logic below and by the bound checker
  logic data_beat, ev_end, ev_start_hdr, ev_ovf, ev_commit, ev_fifo, ev_lost_end;

  assign ring_len = ring_bytes(cfg_ring_idx, BASE_LEN, MAX_IDX);

  rxr_space #(.PTR_W(PTR_W)) u_space (
    .ring_len  (LW'(ring_len)),
    .wr_off    (wr_off),
    .rd_ptr    (rd_ptr),
    .free_bytes(free_bytes),
    .empty     (buf_empty)
  );

  assign len_now = 32'(cnt) + ((cnt == '1) ? 32'd0 : 32'd1);
  assign need    = slot_bytes(len_now);
  assign fits    = need < 32'(free_bytes);
  assign room    = (32'(cnt) + 32'd4) < 32'(free_bytes);

  rxr_status u_status (
    .cls   (in_cls),
    .errs  (in_errs),
    .accept(cfg_accept),
    .len   (len_now[15:0]),
    .take  (take),
    .is_err(frame_err),
    .hdr   (hdr_w)
  );

  assign data_beat    = (st == ST_DATA) && in_valid && !lost;
  assign ev_end       = data_beat && in_last;
  assign ev_start_hdr = ev_end && take && fits;
  assign ev_ovf       = ev_end && take && !fits;
  assign ev_commit    = (st == ST_HDR) && (hk == 2'd3);
  assign ev_fifo      = (st == ST_HDR) && in_valid;
  assign ev_lost_end  = in_valid && in_last && (((st == ST_DATA) && lost) || (st == ST_HDR));

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (st == ST_HDR) begin
      mem_we    = 1'b1;
      mem_addr  = ADDR_W'(32'(wr_off) + 32'(hk));
      mem_wdata = hdr_q[{hk, 3'b000} +: 8];
    end else if (data_beat && room) begin
      mem_we    = 1'b1;
      mem_addr  = ADDR_W'(place(32'(wr_off) + 32'(cnt) + 32'd4, ring_len, cfg_wrap));
      mem_wdata = in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_DATA;
      wr_off <= '0;
      cnt    <= '0;
      lost   <= 1'b0;
      hk     <= '0;
      hdr_q  <= '0;
      nxt_q  <= '0;
      err_q  <= 1'b0;
      rd_ptr <= RD_RESET;
    end else begin
      if (rdptr_we) rd_ptr <= rdptr_wdata;
      case (st)
        ST_DATA: begin
          if (in_valid) begin
            if (in_last) begin
              cnt  <= '0;
              lost <= 1'b0;
            end else if (!lost && cnt != '1) begin
              cnt <= cnt + PTR_W'(1);
            end
          end
          if (ev_start_hdr) begin
            st    <= ST_HDR;
            hk    <= '0;
            hdr_q <= hdr_w;
            err_q <= frame_err;
            nxt_q <= PTR_W'((32'(wr_off) + need) & (ring_len - 32'd1));
          end
        end
        default: begin
          hk <= hk + 2'd1;
          if (in_valid) lost <= !in_last;
          if (ev_commit) begin
            st     <= ST_DATA;
            wr_off <= nxt_q;
          end
        end
      endcase
    end
  end

  rxr_irq #(.MISS_W(MISS_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ok  (ev_commit && !err_q),
    .set_err (ev_commit && err_q),
    .set_ovf (ev_ovf),
    .set_fifo(ev_fifo),
    .clr_we  (int_clr_we),
    .clr_data(int_clr_data),
    .miss_inc(ev_ovf || ev_lost_end),
    .miss_clr(miss_clr),
    .int_stat(int_stat),
    .missed  (missed)
  );

  assign rdptr = rd_ptr;
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 16,
  parameter int MISS_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wrap,
  input logic [31:0]       ring_len,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PTR_W-1:0]  wr_off,
  input logic              ev_commit,
  input logic              ev_ovf,
  input logic              ev_fifo,
  input logic              miss_clr,
  input logic [MISS_W-1:0] missed,
  input logic [15:0]       int_stat,
  input logic              rdptr_we,
  input logic              buf_empty
);
  // R4: frame slots always start on a 4-byte boundary
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n) wr_off[1:0] == 2'b00);

  // R4: the write offset only moves on a commit
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n) !ev_commit |=> $stable(wr_off));

  // R3 / R9: writes stay inside the ring, or the slack when spilling is allowed
  a_r9_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (32'(mem_addr) < ring_len + (cfg_wrap ? 32'd16 : 32'd0)));

  // R6: a committed frame makes the ring non-empty unless software moves the pointer
  a_r6_commit_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_commit && !rdptr_we) |=> !buf_empty);

  // R8: a dropped frame raises the overflow status bit
  a_r8_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n) ev_ovf |=> int_stat[4]);

  // R11: a byte during header write raises the input-overrun bit
  a_r11_fifo_flag: assert property (@(posedge clk) disable iff (!rst_n) ev_fifo |=> int_stat[6]);

  // R12: clear wins, and a drop adds exactly one
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n) miss_clr |=> missed == '0);
  a_r12_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ovf && !miss_clr) |=> missed == $past(missed) + MISS_W'(1));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .MISS_W(MISS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wrap (cfg_wrap),
  .ring_len (ring_len),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .wr_off   (wr_off),
  .ev_commit(ev_commit),
  .ev_ovf   (ev_ovf),
  .ev_fifo  (ev_fifo),
  .miss_clr (miss_clr),
  .missed   (missed),
  .int_stat (int_stat),
  .rdptr_we (rdptr_we),
  .buf_empty(buf_empty)
);

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/100ps
module rx_ring_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_ring_idx = 2'd0;
  logic [5:0]  cfg_accept = 6'b001010;
  logic        cfg_wrap = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_last = 1'b0;
  logic [1:0]  in_cls = 2'd0;
  logic [4:0]  in_errs = 5'd0;
  logic        rdptr_we = 1'b0;
  logic [15:0] rdptr_wdata = 16'd0;
  logic [15:0] rdptr;
  logic        int_clr_we = 1'b0;
  logic [15:0] int_clr_data = 16'd0;
  logic [15:0] int_stat;
  logic        miss_clr = 1'b0;
  logic [23:0] missed;
  logic        buf_empty;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  always #2.5 clk = ~clk;

  rx_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ring_idx(cfg_ring_idx), .cfg_accept(cfg_accept),
    .cfg_wrap(cfg_wrap), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_cls(in_cls), .in_errs(in_errs), .rdptr_we(rdptr_we), .rdptr_wdata(rdptr_wdata),
    .rdptr(rdptr), .int_clr_we(int_clr_we), .int_clr_data(int_clr_data), .int_stat(int_stat),
    .miss_clr(miss_clr), .missed(missed), .buf_empty(buf_empty), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  logic [7:0] mem [int];
  always @(posedge clk) if (mem_we) mem[int'(mem_addr)] = mem_wdata;

  int n_chk = 0, n_fail = 0, seed = 5;
  int exp_wr, exp_rp, exp_int, exp_miss, ring;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int rdm(input int a);
    return mem.exists(a) ? int'(mem[a]) : 0;
  endfunction

  function automatic int b_cons();
    return ((exp_rp + 16) % 65536) % ring;
  endfunction

  function automatic int b_free();
    return ring - ((exp_wr - b_cons() + ring) % ring);
  endfunction

  function automatic int b_addr(input int pos);
    if (!cfg_wrap) return pos % ring;
    if (pos >= ring + 16) return pos - ring;
    return pos;
  endfunction

  function automatic bit b_accept(input int cls, input int errs);
    bit a;
    case (cls)
      0: a = cfg_accept[0];
      1: a = cfg_accept[0] || cfg_accept[1];
      2: a = cfg_accept[2];
      default: a = cfg_accept[3];
    endcase
    if ((errs & 8) != 0) a = a && cfg_accept[4];
    if ((errs & 23) != 0) a = a && cfg_accept[5];
    return a;
  endfunction

  task automatic do_reset(input int idx);
    rst_n = 1'b0;
    cfg_ring_idx = 2'(idx);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mem.delete();
    exp_wr = 0; exp_rp = 16'hFFF0; exp_int = 0; exp_miss = 0;
    ring = 8192 << ((idx > 2) ? 2 : idx);
  endtask

  task automatic consume();
    rdptr_we = 1'b1;
    rdptr_wdata = 16'((exp_wr - 16 + 65536) % 65536);
    @(negedge clk);
    rdptr_we = 1'b0;
    exp_rp = (exp_wr - 16 + 65536) % 65536;
    chk("R6 rdptr readback", int'(rdptr), exp_rp);
    chk("R6 empty after consume", int'(buf_empty), 1);
  endtask

  task automatic frame(input int len, input int cls, input int errs, output bit stored);
    int need, fr, bad, hv, sv, base;
    bit acc_b, fits;
    acc_b = b_accept(cls, errs);
    need = ((len + 7) / 4) * 4;
    fr = b_free();
    fits = need < fr;
    base = seed;
    seed = seed + 13;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data = 8'(base + i * 7);
      in_last = (i == len - 1);
      in_cls = 2'(cls);
      in_errs = 5'(errs);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    repeat (6) @(negedge clk);
    stored = 0;
    if (acc_b && fits) begin
      sv = (errs << 1) | ((errs == 0) ? 1 : 0) | ((cls == 3) ? 32'h2000 : 0)
         | ((cls == 1) ? 32'h4000 : 0) | ((cls == 2) ? 32'h8000 : 0);
      hv = rdm(exp_wr) | (rdm(exp_wr + 1) << 8) | (rdm(exp_wr + 2) << 16) | (rdm(exp_wr + 3) << 24);
      chk("R2 R4 header at predicted offset", hv, (len << 16) | sv);
      bad = 0;
      for (int i = 0; i < len; i++)
        if (rdm(b_addr(exp_wr + 4 + i)) != ((base + i * 7) & 255)) bad++;
      chk(cfg_wrap ? "R9 payload placement" : "R3 payload placement", bad, 0);
      exp_int = exp_int | ((errs != 0) ? 2 : 1);
      exp_wr = (exp_wr + need) % ring;
      stored = 1;
    end else if (acc_b) begin
      exp_miss = (exp_miss + 1) % (1 << 24);
      exp_int = exp_int | 16'h10;
    end
    chk("R10 int_stat", int'(int_stat), exp_int);
    chk("R8 R12 missed", int'(missed), exp_miss);
    chk("R6 R7 empty flag", int'(buf_empty), (b_cons() == exp_wr) ? 1 : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit st;
    int cnt, h0;
    do_reset(0);
    // R1 reset state
    chk("R1 empty", int'(buf_empty), 1);
    chk("R1 rdptr", int'(rdptr), 16'hFFF0);
    chk("R1 int_stat", int'(int_stat), 0);
    chk("R1 missed", int'(missed), 0);
    chk("R1 no write", int'(mem_we), 0);

    // every alignment residue, broadcast
    for (int l = 60; l < 68; l++) begin frame(l, 3, 0, st); consume(); end

    // fold-back sweep across the ring end several times
    for (int k = 0; k < 24; k++) begin frame(200 + 61 * k, 1 + 2 * (k % 2), 0, st); consume(); end

    // spill-into-slack sweep
    cfg_wrap = 1'b1;
    for (int k = 0; k < 24; k++) begin frame(300 + 53 * k, 3, 0, st); consume(); end
    cfg_wrap = 1'b0;

    // R10 clear only the written bits
    int_clr_we = 1'b1; int_clr_data = 16'h0001;
    @(negedge clk);
    int_clr_we = 1'b0;
    exp_int = exp_int & ~1;
    chk("R10 write-one clear", int'(int_stat), exp_int);

    // R7 accept mask
    frame(64, 0, 0, st); chk("R7 other unicast rejected", int'(st), 0);
    frame(64, 2, 0, st); chk("R7 multicast rejected", int'(st), 0);
    frame(64, 3, 2, st); chk("R7 crc frame rejected", int'(st), 0);
    cfg_accept = 6'b000001;
    frame(64, 0, 0, st); consume(); chk("R7 any unicast accepted", int'(st), 1);
    frame(64, 1, 0, st); consume(); chk("R7 own via any", int'(st), 1);
    cfg_accept = 6'b011111;
    frame(40, 3, 8, st); consume(); chk("R7 runt accepted", int'(st), 1);
    frame(64, 3, 2, st); chk("R7 crc still rejected", int'(st), 0);
    cfg_accept = 6'b101111;
    frame(64, 2, 5, st); consume(); chk("R7 errored accepted", int'(st), 1);
    frame(64, 3, 8, st); chk("R7 runt needs its bit", int'(st), 0);
    frame(64, 3, 17, st); consume(); chk("R7 bad symbol accepted", int'(st), 1);
    cfg_accept = 6'b001010;

    // R11 byte arriving during header write
    int_clr_we = 1'b1; int_clr_data = 16'hFFFF;
    @(negedge clk);
    int_clr_we = 1'b0;
    exp_int = 0;
    for (int i = 0; i < 64 + 10; i++) begin
      in_valid = 1'b1; in_data = 8'(i); in_cls = 2'd3; in_errs = 5'd0;
      in_last = (i == 63) || (i == 73);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    repeat (6) @(negedge clk);
    exp_wr = (exp_wr + 68) % ring;
    exp_miss = exp_miss + 1;
    chk("R11 overrun bit", int'(int_stat), 16'h41);
    chk("R11 lost frame counted", int'(missed), exp_miss);
    chk("R11 first frame kept", rdm(exp_wr - 68) | (rdm(exp_wr - 67) << 8) | (rdm(exp_wr - 66) << 16), 32'h400001 | (64 << 16) | 32'h2000);
    consume();
    exp_int = 16'h41;
    frame(80, 3, 0, st); consume(); chk("R11 recovers", int'(st), 1);

    // R12 clear
    miss_clr = 1'b1;
    @(negedge clk);
    miss_clr = 1'b0;
    exp_miss = 0;
    chk("R12 clear", int'(missed), 0);

    // R5 R8 fill without consuming, per size index
    for (int ix = 0; ix < 4; ix += (ix == 1) ? 2 : 1) begin
      do_reset(ix);
      cnt = 0;
      st = 1;
      h0 = 0;
      while (st) begin
        frame(1500, 3, 0, st);
        if (cnt == 0) h0 = rdm(0) | (rdm(1) << 8) | (rdm(2) << 16) | (rdm(3) << 24);
        if (st) cnt++;
      end
      chk("R5 stored frames for ring size", cnt, (ring - 1) / 1504);
      chk("R8 unconsumed data intact", rdm(0) | (rdm(1) << 8) | (rdm(2) << 16) | (rdm(3) << 24), h0);
      chk("R8 overflow bit", int'(int_stat[4]), 1);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule